// File: doc/BRIEF.md
# Load-Use Stall and Bubble Control

This decode-stage unit guards a five-stage pipeline against the one data hazard that operand forwarding cannot cover. A load gets its result from memory one stage too late for the next instruction's ALU operands. The unit compares the destination field of the instruction now in execute with the two source fields of the instruction now in decode. When the instruction in execute is a load and either source field matches, the unit holds the front of the pipeline and sends a no-op down.

The unit holds the front of the pipeline by dropping two write enables, one for the program counter and one for the fetch/decode pipeline register. The same instruction is therefore fetched again and decoded again. In the same cycle it raises a select that zeroes every control bit bound for the decode/execute register, and it also drives that gated control vector. A single dependency costs exactly one cycle. After that cycle the load has moved to the memory stage, the bubble sits in execute with its memory-read flag cleared, the condition drops, and forwarding delivers the loaded value.

The unit is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `load_use_guard`

## Requirements
- R1: A stall is raised when `ex_mem_rd_i` is 1 and `ex_rt_i` equals `dec_rs_i`.
- R2: A stall is raised when `ex_mem_rd_i` is 1 and `ex_rt_i` equals `dec_rt_i`. A match on both fields still gives a single stall indication.
- R3: No stall is raised while `ex_mem_rd_i` is 0, whatever the register fields hold.
- R4: No stall is raised when `ex_rt_i` differs from both `dec_rs_i` and `dec_rt_i`. Register index 0 gets no special treatment.
- R5: During a stall, `pc_we_o` and `fd_we_o` are both 0.
- R6: During a stall, `ctrl_zero_o` is 1 and every bit of `ex_ctrl_o` is 0.
- R7: Without a stall, `pc_we_o` and `fd_we_o` are 1, `ctrl_zero_o` is 0, and `ex_ctrl_o` equals `dec_ctrl_i`.
- R8: In a pipeline built around the unit, each load followed directly by a dependent instruction costs exactly one stall cycle, and no stall lasts two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_rd_i | input | 1 | Memory-read flag of the instruction in execute |
| ex_rt_i | input | REG_AW | Destination (Rt) field of the instruction in execute |
| dec_rs_i | input | REG_AW | Rs source field of the instruction in decode |
| dec_rt_i | input | REG_AW | Rt source field of the instruction in decode |
| dec_ctrl_i | input | CTRL_W | Control bits decoded for the instruction in decode |
| pc_we_o | output | 1 | Program counter write enable |
| fd_we_o | output | 1 | Fetch/decode register write enable |
| ctrl_zero_o | output | 1 | Select that zeroes controls entering execute |
| ex_ctrl_o | output | CTRL_W | Control bits to the decode/execute register after gating |

## Verification
Two functions can fall in the same cycle. The first is a match on Rs and Rt at once, when a loaded register feeds both operands. The second is a load followed directly by another load that reads the first load's target, where the freeze and the bubble then repeat at once for the next pair. The vector table provokes the double match and checks that it still yields a single stall with all controls zeroed. A small pipeline model runs back-to-back dependent loads and checks that each pair costs one cycle, that no stall runs two cycles in a row, and that the total stall count matches the count of dependent pairs.

// File: rtl/load_use_pkg.sv
package load_use_pkg;
  localparam int unsigned DEF_REG_AW = 5;
  localparam int unsigned DEF_CTRL_W = 8;
  // operand sources compared against the load target
  localparam int unsigned NSRC = 2;
  typedef enum logic [0:0] {
    SRC_RS = 1'b0,
    SRC_RT = 1'b1
  } src_sel_e;
endpackage

// File: rtl/reg_match.sv
module reg_match #(
  parameter int unsigned REG_AW = load_use_pkg::DEF_REG_AW,
  parameter int unsigned NSRC   = load_use_pkg::NSRC
) (
  input  logic [REG_AW-1:0]           tgt_i,
  input  logic [NSRC-1:0][REG_AW-1:0] src_i,
  output logic [NSRC-1:0]             hit_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit_o[g] = (src_i[g] == tgt_i);
  end
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl #(
  parameter int unsigned NSRC = load_use_pkg::NSRC
) (
  input  logic            mem_rd_i,
  input  logic [NSRC-1:0] hit_i,
  output logic            pc_we_o,
  output logic            fd_we_o,
  output logic            zero_sel_o
);
  logic stall;

  always_comb begin
    stall      = mem_rd_i && (|hit_i);
    pc_we_o    = !stall;
    fd_we_o    = !stall;
    zero_sel_o = stall;
  end
endmodule

// File: rtl/ctrl_gate.sv
module ctrl_gate #(
  parameter int unsigned CTRL_W = load_use_pkg::DEF_CTRL_W
) (
  input  logic              zero_sel_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
    assign ctrl_o[b] = ctrl_i[b] & ~zero_sel_i;
  end
endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
  import load_use_pkg::*;
#(
  parameter int unsigned REG_AW = DEF_REG_AW,
  parameter int unsigned CTRL_W = DEF_CTRL_W
) (
  input  logic              ex_mem_rd_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  input  logic [REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0] dec_rt_i,
  input  logic [CTRL_W-1:0] dec_ctrl_i,
  output logic              pc_we_o,
  output logic              fd_we_o,
  output logic              ctrl_zero_o,
  output logic [CTRL_W-1:0] ex_ctrl_o
);
  logic [NSRC-1:0][REG_AW-1:0] srcs;
  logic [NSRC-1:0]             hits;

  assign srcs[SRC_RS] = dec_rs_i;
  assign srcs[SRC_RT] = dec_rt_i;

  reg_match #(.REG_AW(REG_AW), .NSRC(NSRC)) u_match (
    .tgt_i (ex_rt_i),
    .src_i (srcs),
    .hit_o (hits)
  );

  stall_ctrl #(.NSRC(NSRC)) u_stall (
    .mem_rd_i   (ex_mem_rd_i),
    .hit_i      (hits),
    .pc_we_o    (pc_we_o),
    .fd_we_o    (fd_we_o),
    .zero_sel_o (ctrl_zero_o)
  );

  ctrl_gate #(.CTRL_W(CTRL_W)) u_gate (
    .zero_sel_i (ctrl_zero_o),
    .ctrl_i     (dec_ctrl_i),
    .ctrl_o     (ex_ctrl_o)
  );

  // port-level checks across the three sub-blocks
  always_comb begin
    if (ex_mem_rd_i && (ex_rt_i == dec_rs_i))
      a_r1_rs_stall: assert (!pc_we_o && ctrl_zero_o);
    if (ex_mem_rd_i && (ex_rt_i == dec_rt_i))
      a_r2_rt_stall: assert (!fd_we_o && ctrl_zero_o);
    if (!ex_mem_rd_i)
      a_r3_no_load: assert (pc_we_o && fd_we_o && !ctrl_zero_o);
    if ((ex_rt_i != dec_rs_i) && (ex_rt_i != dec_rt_i))
      a_r4_no_match: assert (pc_we_o && fd_we_o);
    a_r5_freeze_pair: assert (pc_we_o == fd_we_o);
    if (ctrl_zero_o)
      a_r6_bubble: assert (ex_ctrl_o == '0);
    if (pc_we_o)
      a_r7_pass: assert (ex_ctrl_o == dec_ctrl_i);
  end
endmodule

// File: tb/load_use_guard_bench.sv
module load_use_guard_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW = 5;
  localparam int  CW = 8;
  localparam int  NV = 12;
  localparam int  NPROG = 16;
  localparam logic [CW-1:0] LD_CTRL  = 8'h81;
  localparam logic [CW-1:0] ALU_CTRL = 8'h0F;

  // vector: {mem_rd, ex_rt, rs, rt, ctrl, exp_stall}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 5'd2,  5'd2,  5'd5,  8'hA5, 1'b1},  // R1 rs match
    {1'b1, 5'd7,  5'd1,  5'd7,  8'h3C, 1'b1},  // R2 rt match
    {1'b1, 5'd9,  5'd9,  5'd9,  8'hFF, 1'b1},  // R2 both match
    {1'b0, 5'd4,  5'd4,  5'd4,  8'h5A, 1'b0},  // R3 match, not a load
    {1'b0, 5'd0,  5'd0,  5'd0,  8'h11, 1'b0},  // R3
    {1'b1, 5'd3,  5'd4,  5'd5,  8'hC3, 1'b0},  // R4 mismatch
    {1'b1, 5'd0,  5'd0,  5'd6,  8'h81, 1'b1},  // R4 no index-0 exemption
    {1'b1, 5'd31, 5'd30, 5'd15, 8'h7E, 1'b0},  // R4
    {1'b1, 5'd31, 5'd31, 5'd0,  8'h01, 1'b1},  // R1 top index
    {1'b0, 5'd12, 5'd1,  5'd2,  8'h80, 1'b0},  // R7
    {1'b1, 5'd16, 5'd0,  5'd16, 8'h40, 1'b1},  // R2
    {1'b1, 5'd1,  5'd17, 5'd16, 8'h02, 1'b0}   // R4 single-bit diff
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ex_mem_rd;
  logic [AW-1:0] ex_rt, dec_rs, dec_rt;
  logic [CW-1:0] dec_ctrl;
  logic          pc_we, fd_we, ctrl_zero;
  logic [CW-1:0] ex_ctrl;
  int            checks = 0;
  int            fails  = 0;
  logic          pipe_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_use_guard #(.REG_AW(AW), .CTRL_W(CW)) u_load_use_guard (
    .ex_mem_rd_i (ex_mem_rd),
    .ex_rt_i     (ex_rt),
    .dec_rs_i    (dec_rs),
    .dec_rt_i    (dec_rt),
    .dec_ctrl_i  (dec_ctrl),
    .pc_we_o     (pc_we),
    .fd_we_o     (fd_we),
    .ctrl_zero_o (ctrl_zero),
    .ex_ctrl_o   (ex_ctrl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // program: {is_load, rs, rt}; a load writes its rt field
  logic [10:0] prog [NPROG];
  initial begin
    for (int i = 0; i < NPROG; i++) prog[i] = '0;
    prog[0]  = {1'b1, 5'd1, 5'd2};
    prog[1]  = {1'b0, 5'd2, 5'd5};  // R1 dependent
    prog[2]  = {1'b0, 5'd6, 5'd7};
    prog[3]  = {1'b1, 5'd0, 5'd4};
    prog[4]  = {1'b0, 5'd3, 5'd4};  // R2 dependent
    prog[5]  = {1'b0, 5'd4, 5'd4};  // prior is ALU: no stall
    prog[7]  = {1'b1, 5'd8, 5'd9};
    prog[8]  = {1'b1, 5'd9, 5'd9};  // load using load
    prog[9]  = {1'b0, 5'd9, 5'd9};  // dependent on second load
    prog[10] = {1'b1, 5'd1, 5'd3};
    prog[11] = {1'b0, 5'd5, 5'd6};  // mismatch
  end

  // pipeline model: pc, fetch/decode, decode/execute
  int          pc;
  logic [10:0] fd_q;
  logic        ide_ld;
  logic [AW-1:0] ide_rt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= 0;
      fd_q   <= '0;
      ide_ld <= 1'b0;
      ide_rt <= '0;
    end else if (pipe_en) begin
      if (pc_we) pc <= pc + 1;
      if (fd_we) fd_q <= (pc < NPROG) ? prog[pc] : '0;
      ide_ld <= ex_ctrl[7];
      ide_rt <= fd_q[4:0];
    end
  end

  always_comb begin
    if (pipe_en) begin
      ex_mem_rd = ide_ld;
      ex_rt     = ide_rt;
      dec_rs    = fd_q[9:5];
      dec_rt    = fd_q[4:0];
      dec_ctrl  = fd_q[10] ? LD_CTRL : ALU_CTRL;
    end else begin
      ex_mem_rd = vec_cur[24];
      ex_rt     = vec_cur[23:19];
      dec_rs    = vec_cur[18:14];
      dec_rt    = vec_cur[13:9];
      dec_ctrl  = vec_cur[8:1];
    end
  end

  logic [24:0] vec_cur = '0;

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int stalls, prev_stall, exp_stalls, cycles;
    logic exp_st;
    // reset state: model holds a bubble in execute, unit must not stall
    pipe_en = 1'b1;
    #(CLK_PERIOD * 2 + 1);
    check("R3 reset pc_we", pc_we, 1);
    check("R7 reset fd_we", fd_we, 1);
    check("R7 reset ctrl_zero", ctrl_zero, 0);
    pipe_en = 1'b0;
    rst_n = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_cur = VEC[v];
      #1;
      exp_st = VEC[v][0];
      check("R1/R2/R3/R4 stall", {31'd0, ctrl_zero}, {31'd0, exp_st});
      check("R5/R7 pc_we", pc_we, !exp_st);
      check("R5/R7 fd_we", fd_we, !exp_st);
      check("R6/R7 ex_ctrl", ex_ctrl, exp_st ? 8'h00 : VEC[v][8:1]);
      #(CLK_PERIOD - 1);
    end

    // pipeline run: R8
    rst_n = 1'b0;
    #(CLK_PERIOD);
    @(negedge clk);
    rst_n = 1'b1;
    pipe_en = 1'b1;
    stalls = 0; prev_stall = 0; cycles = 0;
    exp_stalls = 4;
    while (pc < NPROG + 2 && cycles < 100) begin
      @(negedge clk);
      cycles++;
      exp_st = ide_ld && ((ide_rt == fd_q[9:5]) || (ide_rt == fd_q[4:0]));
      check("R8 stall matches model", {31'd0, ctrl_zero}, {31'd0, exp_st});
      if (ctrl_zero) begin
        stalls++;
        check("R6 bubble controls zero", ex_ctrl, 0);
        check("R8 no back-to-back stall", prev_stall, 0);
      end
      prev_stall = ctrl_zero;
    end
    check("R8 stall count", stalls, exp_stalls);
    check("R8 cycle count", cycles, NPROG + 2 + exp_stalls);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule